// File: doc/BRIEF.md
# Five-Channel 6-Bit Pulse-Width Output Bank

This block drives five pins with pulse-width signals for analog set points such as volume or brightness; an external RC network filters each pin. A divide-by-three strobe paces a shared 6-bit step counter, so every channel repeats each 64 steps (192 clocks). A channel stays high for as many steps as its stored 6-bit value. One shared bit inverts every channel that is in pulse mode.

Each pin has a mode bit. When the bit is set, the pin carries the channel's pulse waveform. When it is clear, the pin carries a general-purpose port data bit, which the shared inversion bit does not affect. Software reaches the channel values and the control word through a single-cycle write strobe with an address and data. A value that is written is held back until the next period begins, so a period is never cut short or stretched.

Top module: `ana_pwm_bank`

## Requirements
- R1: While reset is high, all pins are 0. After reset, every channel is in port mode, every stored value is 0 and inversion is off.
- R2: Address k (0 to 4) writes wr_data[5:0] as the value of channel k, which drives pin_o[k]. Address 5 writes the control word: bit k (0 to 4) is the pulse-mode bit of channel k, and bit 5 is the shared inversion bit.
- R3: The step strobe fires once every 3 clocks. A pulse period is 64 steps, so rising edges of a channel pin come 192 clocks apart.
- R4: In pulse mode with inversion off, a channel with value v is high for 3*v consecutive clocks of every 192. The high stretch starts at the beginning of each period.
- R5: Value 0 gives a pin that is always low. Value 63 gives 189 high clocks out of every 192.
- R6: With the inversion bit at 1, every channel in pulse mode is inverted: it is high for 192-3*v clocks per period, and value 0 gives a pin that is always high.
- R7: A channel in port mode copies port_i[k] to pin_o[k] one clock later, whatever the inversion bit holds.
- R8: A value written partway through a period does not change that period. It takes effect from the next period.
- R9: A value written in the last clock of a period, which is also the clock in which the channel loads its next value, is used for the period that starts right after.
- R10: Writes to addresses 6 and 7 change no channel value and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the 3:1 step strobe is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write address (0-4 channel values, 5 control) |
| wr_data | input | 6 | Write data |
| port_i | input | 5 | Port data bits used by channels in port mode |
| pin_o | output | 5 | Registered pin outputs, bit k for channel k |

## Verification
A software write and the period-boundary load can land on the same clock edge. The bench aligns itself to a channel's rising pin edge. It then counts exactly 190 negative edges and places a one-cycle write so that the write is captured on the edge that loads the channel. The bench then requires the new value to show up in the very next high pulse. The same write issued one clock later must leave that pulse at the old width and only show in the period after, which pins the merge to the exact load cycle.

// File: rtl/ana_pwm_pkg.sv
package ana_pwm_pkg;
  localparam int unsigned PWM_CH_DEF  = 5;
  localparam int unsigned PWM_W_DEF   = 6;
  localparam int unsigned PWM_DIV_DEF = 3;

  function automatic int unsigned bus_width(int unsigned nch, int unsigned dw);
    return (nch + 1 > dw) ? nch + 1 : dw;
  endfunction
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  output logic [W-1:0] phase_o,
  output logic         wrap_o
);
  always_ff @(posedge clk) begin
    if (rst)         phase_o <= '0;
    else if (tick_i) phase_o <= phase_o + 1'b1;
  end

  // the step that rolls the counter back to zero starts a new period
  assign wrap_o = tick_i && (phase_o == '1);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         load_i,
  input  logic [W-1:0] phase_i,
  input  logic         pulse_en_i,
  input  logic         invert_i,
  input  logic         port_bit_i,
  output logic [W-1:0] act_o,
  output logic         pin_o
);
  logic [W-1:0] pend_q;
  logic         raw;

  always_ff @(posedge clk) begin
    if (rst)           pend_q <= '0;
    else if (wr_hit_i) pend_q <= wr_val_i;
  end

  // a write landing in the load cycle is forwarded straight into the period
  always_ff @(posedge clk) begin
    if (rst)         act_o <= '0;
    else if (load_i) act_o <= wr_hit_i ? wr_val_i : pend_q;
  end

  assign raw = (phase_i < act_o);

  always_ff @(posedge clk) begin
    if (rst) pin_o <= 1'b0;
    else     pin_o <= pulse_en_i ? (raw ^ invert_i) : port_bit_i;
  end
endmodule

// File: rtl/ana_pwm_bank.sv
module ana_pwm_bank #(
  parameter int unsigned NCH = ana_pwm_pkg::PWM_CH_DEF,
  parameter int unsigned DW  = ana_pwm_pkg::PWM_W_DEF,
  parameter int unsigned DIV = ana_pwm_pkg::PWM_DIV_DEF,
  localparam int unsigned AW = $clog2(NCH + 1),
  localparam int unsigned BW = ana_pwm_pkg::bus_width(NCH, DW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [BW-1:0]  wr_data,
  input  logic [NCH-1:0] port_i,
  output logic [NCH-1:0] pin_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic              tick;
  logic              wrap;
  logic [DW-1:0]     phase;
  logic [NCH-1:0]    en_q;
  logic              pol_q;
  logic [NCH*DW-1:0] act_flat;

  pwm_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  pwm_phase_gen #(.W(DW)) u_phase (
    .clk(clk), .rst(rst), .tick_i(tick), .phase_o(phase), .wrap_o(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= 1'b0;
    end else if (wr_en && wr_addr == CTRL_ADDR) begin
      en_q  <= wr_data[NCH-1:0];
      pol_q <= wr_data[NCH];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(k));

    pwm_chan #(.W(DW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_hit_i(hit), .wr_val_i(wr_data[DW-1:0]),
      .load_i(wrap), .phase_i(phase),
      .pulse_en_i(en_q[k]), .invert_i(pol_q), .port_bit_i(port_i[k]),
      .act_o(act_flat[k*DW +: DW]), .pin_o(pin_o[k])
    );
  end
endmodule

// File: rtl/ana_pwm_bank_chk.sv
module ana_pwm_bank_chk #(
  parameter int unsigned NCH = 5,
  parameter int unsigned DW  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wrap,
  input logic [DW-1:0]     phase,
  input logic [NCH*DW-1:0] act_flat,
  input logic [NCH-1:0]    en_q,
  input logic [NCH-1:0]    port_i,
  input logic [NCH-1:0]    pin_o
);
  // R1: pins held low through reset
  p_rst_low_r1: assert property (@(posedge clk) rst |=> (pin_o == '0));

  // R3: strobe spacing of three clocks
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  p_tick_gap2_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> ##1 !tick);

  // R3: step counter advances on the strobe only
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (phase == DW'($past(phase) + 1)));
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  // R8: active values move only at the period boundary
  p_act_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_flat));

  // R7: port-mode pins copy port data one clock later
  for (genvar k = 0; k < NCH; k++) begin : g_pm
    p_port_copy_r7: assert property (@(posedge clk) disable iff (rst)
      !en_q[k] |=> (pin_o[k] == $past(port_i[k])));
  end
endmodule

bind ana_pwm_bank ana_pwm_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wrap(wrap), .phase(phase),
  .act_flat(act_flat), .en_q(en_q), .port_i(port_i), .pin_o(pin_o)
);

// File: tb/ana_pwm_bank_test.sv
module ana_pwm_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic [4:0] port_i = 5'h1f;
  logic [4:0] pin_o;

  int total = 0;
  int bad = 0;
  bit busy = 1'b0;
  bit done = 1'b0;

  typedef struct {int ch; int exp; string req;} item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  ana_pwm_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_i(port_i), .pin_o(pin_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 6'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver side of the scoreboard: queue an expected high count per 192 clocks
  task automatic expect_duty(input int ch, input int exp, input string req);
    item_t it;
    it.ch = ch; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0 && !busy);
  endtask

  // monitor side: high count over one full period window
  initial begin
    forever begin
      item_t it;
      int hi;
      wait (sb_q.size() > 0);
      busy = 1'b1;
      it = sb_q.pop_front();
      hi = 0;
      for (int i = 0; i < 192; i++) begin
        @(negedge clk);
        if (pin_o[it.ch]) hi++;
      end
      check(it.req, hi, it.exp);
      busy = 1'b0;
    end
  end

  task automatic find_rise(input int ch);
    logic prev;
    @(negedge clk);
    prev = pin_o[ch];
    forever begin
      @(negedge clk);
      if (pin_o[ch] && !prev) break;
      prev = pin_o[ch];
    end
  endtask

  task automatic run_len(input int ch, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (pin_o[ch]) n++;
      else break;
    end
  endtask

  initial begin
    int n;
    int gap;
    // R1: reset state
    idle(3);
    check("R1 pins low in reset", int'(pin_o), 0);
    rst = 1'b0;
    idle(2);
    check("R1/R7 port mode after reset", int'(pin_o), 5'h1f);
    port_i = 5'h0a;
    @(negedge clk);
    check("R7 port copy one clock later", int'(pin_o), 5'h0a);

    // R2/R4/R5: values and pulse mode on all channels
    wr(0, 0); wr(1, 1); wr(2, 32); wr(3, 63); wr(4, 17);
    wr(5, 6'h1f);
    idle(400);
    expect_duty(0, 0,   "R5 value 0 always low");
    expect_duty(1, 3,   "R4 value 1");
    expect_duty(2, 96,  "R4 value 32");
    expect_duty(3, 189, "R5 value 63");
    expect_duty(4, 51,  "R2 address 4 value 17");

    // R6: inversion
    wr(5, 6'h3f);
    idle(400);
    expect_duty(0, 192, "R6 inverted value 0");
    expect_duty(3, 3,   "R6 inverted value 63");
    expect_duty(4, 141, "R6 inverted value 17");

    // R7: port mode ignores inversion
    wr(5, 6'h25);
    port_i = 5'h1f;
    idle(2);
    check("R7 port bits with inversion on", int'(pin_o & 5'h1a), 5'h1a);
    port_i = 5'h00;
    idle(2);
    check("R7 port bits low with inversion on", int'(pin_o & 5'h1a), 0);
    expect_duty(2, 96, "R6 inverted value 32 in mixed mode");

    // R10: unused addresses
    wr(6, 0); wr(7, 0);
    idle(400);
    expect_duty(0, 192, "R10 control unchanged");
    expect_duty(2, 96,  "R10 value unchanged");
    port_i = 5'h08;
    idle(2);
    check("R10 mode bits unchanged", int'(pin_o & 5'h1a), 5'h08);

    // R3: period length
    wr(5, 6'h01); wr(0, 32);
    idle(400);
    find_rise(0);
    gap = 0;
    begin
      logic prev;
      prev = 1'b1;
      forever begin
        @(negedge clk);
        gap++;
        if (pin_o[0] && !prev) break;
        prev = pin_o[0];
      end
    end
    check("R3 rise to rise 192 clocks", gap, 192);

    // R8: mid-period write waits for the next period
    find_rise(0);
    n = 1;
    for (int j = 1; ; j++) begin
      @(negedge clk);
      if (j == 10) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 6'd5; end
      if (j == 11) wr_en = 1'b0;
      if (pin_o[0]) n++;
      else break;
    end
    check("R8 current period keeps old width", n, 96);
    find_rise(0);
    run_len(0, n);
    check("R8 next period new width", n, 15);

    // R9: write in the load cycle
    find_rise(0);
    for (int j = 1; j <= 191; j++) begin
      @(negedge clk);
      if (j == 190) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 6'd40; end
      if (j == 191) wr_en = 1'b0;
    end
    @(negedge clk);
    check("R9 rise right after load", int'(pin_o[0]), 1);
    run_len(0, n);
    check("R9 load-cycle write used at once", n, 120);

    // R8: write one clock after the load is deferred a full period
    find_rise(0);
    for (int j = 1; j <= 192; j++) begin
      @(negedge clk);
      if (j == 191) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 6'd7; end
      if (j == 192) wr_en = 1'b0;
    end
    check("R8 rise after boundary", int'(pin_o[0]), 1);
    run_len(0, n);
    check("R8 late write not in this period", n, 120);
    find_rise(0);
    run_len(0, n);
    check("R8 late write in following period", n, 21);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule